// File: doc/BRIEF.md
# Safety Error Status Aggregator

This block gathers hardware safety events from three sources: the MAC datapath and its control state machines, the queue memories of the transaction layer (MTL), and the DMA offload memory. Each source reports an event as a one-cycle pulse with a 5-bit bit position. The event is latched into a 32-bit sticky status word for that source. Software clears bits by writing ones to the same positions.

From the three status words the block derives summary flags and one combined interrupt line. Flags are split into correctable and uncorrectable classes. Each protected memory reports a group of three bits: a correctable error, an address mismatch, and an uncorrectable error. The first bit counts as correctable. The other two count as uncorrectable. Every MAC event counts as uncorrectable.

A 2-bit safety level selects which error classes are armed. Events outside the armed classes, and events at reserved positions, are dropped.

Top module: `safety_err_agg`

## Requirements
- R1: After reset, all three status words, the safety level and the interrupt enables are zero, and every flag and the interrupt are low.
- R2: An event at an armed, valid position sets that status bit after the next clock edge. The bit then stays set until software clears it.
- R3: A write with reg_addr 0 (MAC), 1 (MTL) or 2 (DMA) clears exactly the status bits whose wdata bit is 1. The other bits are unchanged.
- R4: If an event and a clear hit the same bit in the same cycle, the event wins and the bit stays set.
- R5: Some positions are never valid and never set. For MAC these are bits 20-23 and 25-31. For MTL, valid bits are 0-2, 4-6, 8-10 and 12-14. For DMA, valid bits are 0-2.
- R6: The level is written at reg_addr 4, in wdata[1:0]. Level 0 arms nothing. Level 1 arms the MTL and DMA memory bits. Level 2 also arms MAC bits 1-4, 6-19 and 24. Level 3 also arms MAC bits 0 and 5, the external interface parity bits.
- R7: mac_unc is high whenever any MAC status bit is set. MAC events never raise a correctable flag.
- R8: Memory triplets sit at MTL bits 0, 4, 8 and 12 (TX, RX, scheduler list, RX parser) and at DMA bit 0. Offset 0 of a triplet feeds the correctable flag. Offsets 1 and 2 feed the uncorrectable flag.
- R9: A summary flag stays high while any bit that feeds it is set. It falls in the cycle after the clear of the last such bit.
- R10: irq is high when any uncorrectable flag is high, or when a correctable bit is set and its enable is set. The enables are written at reg_addr 3: wdata bit 0 is TX, bit 1 is RX, bit 2 is scheduler, bit 3 is parser and bit 4 is DMA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mac_evt_vld | input | 1 | MAC event pulse |
| mac_evt_idx | input | 5 | MAC event bit position |
| mtl_evt_vld | input | 1 | MTL event pulse |
| mtl_evt_idx | input | 5 | MTL event bit position |
| dma_evt_vld | input | 1 | DMA event pulse |
| dma_evt_idx | input | 5 | DMA event bit position |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Write data |
| mac_status | output | 32 | MAC sticky status |
| mtl_status | output | 32 | MTL sticky status |
| dma_status | output | 32 | DMA sticky status |
| mac_unc | output | 1 | MAC uncorrectable summary |
| mtl_corr | output | 1 | MTL correctable summary |
| mtl_unc | output | 1 | MTL uncorrectable summary |
| dma_corr | output | 1 | DMA correctable summary |
| dma_unc | output | 1 | DMA uncorrectable summary |
| irq | output | 1 | Combined interrupt |

## Verification
The bench drives an event and a clear at the same bit in the same cycle. A design that lets the clear win loses a fresh error.

It steps the safety level through every value and fires MAC events at the external interface positions and at the other MAC positions. A wrong arming table either sets bits that should be dropped, or misses bits that should be recorded. It also fires events at reserved positions, which a design missing a valid mask would latch.

It clears a triplet in parts, and it toggles the correctable enables one memory at a time. An address mismatch sorted into the correctable class, a flag that falls early, or an enable wired to the wrong memory would each show up on irq or on a summary flag.

// File: rtl/safety_agg_pkg.sv
package safety_agg_pkg;
  localparam int STAT_W      = 32;
  localparam int IDX_W       = $clog2(STAT_W);
  localparam int MTL_TRIPS   = 4;
  localparam int DMA_TRIPS   = 1;
  localparam int TRIP_STRIDE = 4;
  localparam int LVL_W       = 2;
  localparam int IEN_W       = MTL_TRIPS + DMA_TRIPS;

  localparam logic [STAT_W-1:0] MAC_VALID    = 32'h010F_FFFF;
  localparam logic [STAT_W-1:0] MAC_EXT_PORT = 32'h0000_0021;

  typedef enum logic [2:0] {
    SEL_MAC = 3'd0, SEL_MTL = 3'd1, SEL_DMA = 3'd2, SEL_IEN = 3'd3, SEL_LVL = 3'd4
  } reg_sel_e;

  // Bits of all triplets at offset off (0 = correctable, 1/2 = uncorrectable)
  function automatic logic [STAT_W-1:0] trip_bits(int ntrip, int stride, int off);
    logic [STAT_W-1:0] m = '0;
    for (int i = 0; i < ntrip; i++) m[i*stride+off] = 1'b1;
    return m;
  endfunction

  function automatic logic [STAT_W-1:0] trip_valid(int ntrip, int stride);
    return trip_bits(ntrip, stride, 0) | trip_bits(ntrip, stride, 1) |
           trip_bits(ntrip, stride, 2);
  endfunction

  function automatic logic [STAT_W-1:0] mac_arm(logic [LVL_W-1:0] lvl);
    if (lvl == 2'd3)      return MAC_VALID;
    else if (lvl == 2'd2) return MAC_VALID & ~MAC_EXT_PORT;
    else                  return '0;
  endfunction

  function automatic logic [STAT_W-1:0] mem_arm(logic [LVL_W-1:0] lvl);
    return (lvl != '0) ? '1 : '0;
  endfunction
endpackage

// File: rtl/sticky_status_reg.sv
module sticky_status_reg
  import safety_agg_pkg::*;
#(
  parameter int              WIDTH = STAT_W,
  parameter int              IW    = $clog2(WIDTH),
  parameter logic [WIDTH-1:0] VALID = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_vld,
  input  logic [IW-1:0]    evt_idx,
  input  logic [WIDTH-1:0] arm,
  input  logic             clr_we,
  input  logic [WIDTH-1:0] clr_data,
  output logic [WIDTH-1:0] status_q
);
  logic [WIDTH-1:0] set_vec, clr_vec;
  logic             evt_hit;

  assign set_vec = evt_vld ? ((WIDTH'(1) << evt_idx) & VALID & arm) : '0;
  assign clr_vec = clr_we ? clr_data : '0;
  assign evt_hit = |set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_vec) | set_vec;
  end

  // R4
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_hit |=> status_q[$past(evt_idx)]);
  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((status_q & $past(status_q)) == $past(status_q)));
  // R5
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & ~VALID) == '0);
endmodule

// File: rtl/triplet_rollup.sv
module triplet_rollup
  import safety_agg_pkg::*;
#(
  parameter int NTRIP  = MTL_TRIPS,
  parameter int STRIDE = TRIP_STRIDE
) (
  input  logic [STAT_W-1:0] status,
  input  logic [NTRIP-1:0]  cen,
  output logic              corr_any,
  output logic              unc_any,
  output logic              corr_irq
);
  localparam logic [STAT_W-1:0] CORR_M = trip_bits(NTRIP, STRIDE, 0);
  localparam logic [STAT_W-1:0] UNC_M  = trip_bits(NTRIP, STRIDE, 1) |
                                         trip_bits(NTRIP, STRIDE, 2);
  logic [STAT_W-1:0] en_spread;

  always_comb begin
    en_spread = '0;
    for (int g = 0; g < NTRIP; g++) en_spread[g*STRIDE] = cen[g];
  end

  assign corr_any = |(status & CORR_M);
  assign unc_any  = |(status & UNC_M);
  assign corr_irq = |(status & CORR_M & en_spread);
endmodule

// File: rtl/safety_ctrl_regs.sv
module safety_ctrl_regs
  import safety_agg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [STAT_W-1:0] reg_wdata,
  output logic [LVL_W-1:0] level_q,
  output logic [IEN_W-1:0] ien_q,
  output logic             clr_mac,
  output logic             clr_mtl,
  output logic             clr_dma
);
  assign clr_mac = reg_we && (reg_addr == SEL_MAC);
  assign clr_mtl = reg_we && (reg_addr == SEL_MTL);
  assign clr_dma = reg_we && (reg_addr == SEL_DMA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      ien_q   <= '0;
    end else if (reg_we) begin
      if (reg_addr == SEL_LVL) level_q <= reg_wdata[LVL_W-1:0];
      if (reg_addr == SEL_IEN) ien_q   <= reg_wdata[IEN_W-1:0];
    end
  end

  // R3
  one_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clr_mac, clr_mtl, clr_dma}));
endmodule

// File: rtl/safety_err_agg.sv
module safety_err_agg
  import safety_agg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mac_evt_vld,
  input  logic [4:0]  mac_evt_idx,
  input  logic        mtl_evt_vld,
  input  logic [4:0]  mtl_evt_idx,
  input  logic        dma_evt_vld,
  input  logic [4:0]  dma_evt_idx,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] mac_status,
  output logic [31:0] mtl_status,
  output logic [31:0] dma_status,
  output logic        mac_unc,
  output logic        mtl_corr,
  output logic        mtl_unc,
  output logic        dma_corr,
  output logic        dma_unc,
  output logic        irq
);
  logic [LVL_W-1:0] level_q;
  logic [IEN_W-1:0] ien_q;
  logic             clr_mac, clr_mtl, clr_dma;
  logic             mtl_cirq, dma_cirq;

  safety_ctrl_regs u_regs (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata,
    .level_q, .ien_q, .clr_mac, .clr_mtl, .clr_dma
  );

  sticky_status_reg #(.VALID(MAC_VALID)) u_mac (
    .clk, .rst_n, .evt_vld(mac_evt_vld), .evt_idx(mac_evt_idx),
    .arm(mac_arm(level_q)), .clr_we(clr_mac), .clr_data(reg_wdata),
    .status_q(mac_status)
  );
  sticky_status_reg #(.VALID(trip_valid(MTL_TRIPS, TRIP_STRIDE))) u_mtl (
    .clk, .rst_n, .evt_vld(mtl_evt_vld), .evt_idx(mtl_evt_idx),
    .arm(mem_arm(level_q)), .clr_we(clr_mtl), .clr_data(reg_wdata),
    .status_q(mtl_status)
  );
  sticky_status_reg #(.VALID(trip_valid(DMA_TRIPS, TRIP_STRIDE))) u_dma (
    .clk, .rst_n, .evt_vld(dma_evt_vld), .evt_idx(dma_evt_idx),
    .arm(mem_arm(level_q)), .clr_we(clr_dma), .clr_data(reg_wdata),
    .status_q(dma_status)
  );

  triplet_rollup #(.NTRIP(MTL_TRIPS)) u_mtl_roll (
    .status(mtl_status), .cen(ien_q[MTL_TRIPS-1:0]),
    .corr_any(mtl_corr), .unc_any(mtl_unc), .corr_irq(mtl_cirq)
  );
  triplet_rollup #(.NTRIP(DMA_TRIPS)) u_dma_roll (
    .status(dma_status), .cen(ien_q[IEN_W-1 -: DMA_TRIPS]),
    .corr_any(dma_corr), .unc_any(dma_unc), .corr_irq(dma_cirq)
  );

  assign mac_unc = |mac_status;
  assign irq     = mac_unc | mtl_unc | dma_unc | mtl_cirq | dma_cirq;

  // R10
  unc_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_unc || mtl_unc || dma_unc) |-> irq);
  // R6
  level0_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q == '0 && !reg_we) |=> $stable(mtl_status) && $stable(dma_status) && $stable(mac_status));
  // R7
  mac_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mac_unc) |-> $past(mac_evt_vld));
endmodule

// File: tb/safety_err_agg_test.sv
module safety_err_agg_test;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mac_evt_vld = 0, mtl_evt_vld = 0, dma_evt_vld = 0;
  logic [4:0] mac_evt_idx = 0, mtl_evt_idx = 0, dma_evt_idx = 0;
  logic reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] mac_status, mtl_status, dma_status;
  logic mac_unc, mtl_corr, mtl_unc, dma_corr, dma_unc, irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  safety_err_agg uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  // sub: 0 MAC, 1 MTL, 2 DMA
  task automatic ev(int sub, logic [4:0] idx);
    @(negedge clk);
    case (sub)
      0: begin mac_evt_vld = 1; mac_evt_idx = idx; end
      1: begin mtl_evt_vld = 1; mtl_evt_idx = idx; end
      default: begin dma_evt_vld = 1; dma_evt_idx = idx; end
    endcase
    @(negedge clk); mac_evt_vld = 0; mtl_evt_vld = 0; dma_evt_vld = 0;
  endtask

  task automatic t_reset();
    chk("R1 mac", mac_status, 0); chk("R1 mtl", mtl_status, 0);
    chk("R1 dma", dma_status, 0);
    chk("R1 flags", {mac_unc, mtl_corr, mtl_unc, dma_corr, dma_unc, irq}, 0);
  endtask

  task automatic t_level0();
    ev(1, 0); ev(2, 2); ev(0, 8);
    chk("R6 lvl0 mtl", mtl_status, 0); chk("R6 lvl0 dma", dma_status, 0);
    chk("R6 lvl0 mac", mac_status, 0);
  endtask

  task automatic t_mem_level1();
    wr(4, 1);
    ev(0, 8); chk("R6 lvl1 mac off", mac_status, 0);
    ev(1, 0);
    chk("R2 mtl set", mtl_status, 32'h1);
    chk("R8 mtl corr", {mtl_corr, mtl_unc}, 2'b10);
    chk("R10 corr masked", irq, 0);
    wr(3, 32'h1); chk("R10 tx en", irq, 1);
    ev(1, 3); chk("R5 mtl bit3", mtl_status, 32'h1);
    wr(1, 32'h1);
    chk("R3 mtl clr", mtl_status, 0); chk("R9 corr drop", mtl_corr, 0);
    wr(3, 0);
  endtask

  task automatic t_partial();
    ev(1, 4); ev(1, 10);
    chk("R8 mtl both", {mtl_corr, mtl_unc}, 2'b11);
    chk("R10 unc irq", irq, 1);
    @(negedge clk); reg_we = 1; reg_addr = 1; reg_wdata = 32'h400;
    #1 chk("R9 before edge", mtl_unc, 1);
    @(negedge clk); reg_we = 0;
    chk("R3 partial", mtl_status, 32'h10);
    chk("R9 unc drop", {mtl_corr, mtl_unc}, 2'b10);
    wr(3, 32'h1); chk("R10 wrong en", irq, 0);
    wr(3, 32'h3); chk("R10 rx en", irq, 1);
    wr(1, 32'h10); chk("R9 all clear", {mtl_corr, irq}, 0);
    wr(3, 0);
  endtask

  task automatic t_evt_wins();
    ev(1, 12);
    @(negedge clk); reg_we = 1; reg_addr = 1; reg_wdata = 32'h1000;
    mtl_evt_vld = 1; mtl_evt_idx = 12;
    @(negedge clk); reg_we = 0; mtl_evt_vld = 0;
    chk("R4 evt wins", mtl_status, 32'h1000);
    wr(1, 32'h1000); chk("R4 then clear", mtl_status, 0);
  endtask

  task automatic t_dma();
    ev(2, 1);
    chk("R8 dma mismatch", {dma_corr, dma_unc, irq}, 3'b011);
    ev(2, 0); ev(2, 5);
    chk("R5 dma bit5", dma_status, 32'h3);
    wr(2, 32'h2);
    chk("R8 dma corr only", {dma_corr, dma_unc, irq}, 3'b100);
    wr(3, 32'h10); chk("R10 dma en", irq, 1);
    wr(2, 32'h1); chk("R3 dma clr", dma_status, 0);
    wr(3, 0);
  endtask

  task automatic t_mac();
    wr(4, 2);
    ev(0, 8);
    chk("R6 lvl2 mac", mac_status, 32'h100);
    chk("R7 mac unc", {mac_unc, irq}, 2'b11);
    ev(0, 0); chk("R6 lvl2 ext off", mac_status, 32'h100);
    wr(4, 3);
    ev(0, 0); ev(0, 24); ev(0, 21);
    chk("R6 lvl3 ext", mac_status, 32'h0100_0101);
    chk("R5 mac 21", mac_status[21], 0);
    chk("R7 no corr", {mtl_corr, dma_corr}, 0);
    wr(0, 32'h0100_0101);
    chk("R9 mac drop", {mac_unc, irq}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset(); t_level0(); t_mem_level1(); t_partial();
    t_evt_wins(); t_dma(); t_mac();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (5000) @(posedge clk); failures++;
        $display("FAIL watchdog actual=1 expected=0"); end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule